// File: doc/BRIEF.md
# Partial-Doubleword Store Byte Steering

This unit sits in a store path. It takes one request to store part of a register and turns it into exactly one aligned memory write with per-byte enables. The request gives an effective address, a 64-bit register value, a fill direction (begin or end), a unit size (a 4-byte word or an 8-byte doubleword), a base-modify flag and a 64-bit-mode enable. A begin fill covers the addressed byte and every byte after it up to the end of the aligned unit. An end fill covers every byte before the addressed byte. Both fills take their bytes from the value in big-endian order, so no byte is shifted. It only lands on the lane that it targets.

Every partial update of 3, 5, 6 or 7 bytes leaves the unit as a single write with one combined byte mask, so the memory sees it as one indivisible update. An end fill at offset zero writes nothing. It still emits a transaction marked as a probe, so the memory side can check protection and mark the line dirty. If the doubleword size is requested while 64-bit mode is off, the unit emits a transaction flagged illegal, with no bytes enabled. The result sits in an output register with a valid/ready handshake. When the base-modify flag is set, the unit also returns the base writeback value.

Top module: `partial_store_steer`

## Requirements
- R1: After reset, wr_valid, wr_be, wr_probe, wr_illegal and wb_valid are all zero and req_ready is one.
- R2: Doubleword begin fill: with k = addr[2:0], wr_be[j] is set for lanes j = k..7. Lane j is wr_data[63-8j -: 8], and lane 0 is the lowest address and the most significant byte. Each enabled lane j carries value byte j (value[63-8j -: 8]). wr_addr is addr with bits [2:0] cleared.
- R3: Doubleword end fill: wr_be[j] is set for lanes j = 0..k-1, and each enabled lane carries value byte j. These are the k most significant bytes.
- R4: An end fill with offset zero gives wr_be = 0 and wr_probe = 1. No other case sets wr_probe.
- R5: Word size: k = addr[1:0] and the unit occupies lanes 4*addr[2] to 4*addr[2]+3. Unit byte i carries value[31-8i -: 8]. The begin and end rules of R2 and R3 apply within the unit. wr_addr is addr with bits [1:0] cleared.
- R6: Each accepted request produces exactly one transaction, and all its bytes are in one mask (for example wr_be = 8'hF8 for a begin fill at offset 3). When no further request arrives, wr_valid is low after that transaction is taken.
- R7: A doubleword request with wide_en = 0 gives wr_illegal = 1, wr_be = 0, wr_probe = 0 and wb_valid = 0. A word request is legal whatever the value of wide_en.
- R8: For a legal request with req_modify = 1, wb_valid = 1 and wb_value = addr with bits [2:0] cleared. Otherwise wb_valid = 0.
- R9: req_ready = !wr_valid || wr_ready. An accepted request appears on the outputs after the next clock edge. All outputs hold steady while wr_valid is high and wr_ready is low.
- R10: wr_be is zero whenever wr_valid is low. Data lanes whose enable is clear are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 64 | Effective byte address |
| req_value | input | 64 | Register value to store |
| req_fill_end | input | 1 | 0 = begin fill, 1 = end fill |
| req_modify | input | 1 | Produce a base writeback value |
| req_dword | input | 1 | 1 = doubleword unit, 0 = word unit |
| wide_en | input | 1 | 64-bit mode enabled |
| wr_valid | output | 1 | Write transaction present |
| wr_ready | input | 1 | Downstream takes the transaction |
| wr_addr | output | 64 | Unit-aligned write address |
| wr_data | output | 64 | Write data on big-endian lanes |
| wr_be | output | 8 | Byte enables, bit j for lane j |
| wr_probe | output | 1 | Zero-length probe write |
| wr_illegal | output | 1 | Illegal-instruction indication |
| wb_valid | output | 1 | Base writeback valid |
| wb_value | output | 64 | Base writeback value |

## Verification
The main function is driven with one fixed value whose bytes are all distinct. A wrong lane or a shifted byte therefore shows up as a wrong byte, not just a wrong mask. The offsets are swept through 0, 1, 3, 5, 6 and 7 in both fill directions. This separates the begin mask from the end mask, finds off-by-one errors at the unit edges, and catches the probe-only case at offset zero. Word requests in both halves of the doubleword show whether the unit base follows addr[2] and whether the low half of the value is used. The same requests with 64-bit mode off separate the illegal doubleword case from the legal word case. A second value is sent under backpressure, which shows that the output register holds and then picks up the queued request.

// File: rtl/psb_pkg.sv
package psb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    FILL_BEGIN = 1'b0,
    FILL_END   = 1'b1
  } fill_e;
endpackage

// File: rtl/psb_mask_gen.sv
module psb_mask_gen #(
  parameter int LANES = 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [OFS_W-1:0]   ofs,
  input  logic [OFS_W-1:0]   base,
  input  logic               unit_dw,
  input  psb_pkg::fill_e     fill,
  output logic [LANES-1:0]   mask,
  output logic               zero_len
);
  localparam int HALF = LANES / 2;

  function automatic logic [LANES-1:0] fill_mask(input int k, input int n, input logic is_end);
    logic [LANES-1:0] m;
    m = '0;
    for (int j = 0; j < LANES; j++) begin
      if (j < n) m[j] = is_end ? (j < k) : (j >= k);
    end
    return m;
  endfunction

  logic [LANES-1:0] unit_mask;

  always_comb begin
    unit_mask = fill_mask(int'(ofs), unit_dw ? LANES : HALF, fill == psb_pkg::FILL_END);
    mask      = unit_mask << base;
    zero_len  = (fill == psb_pkg::FILL_END) && (ofs == '0);
  end
endmodule

// File: rtl/psb_lane_align.sv
module psb_lane_align #(
  parameter int LANES = 8,
  localparam int DATA_W = LANES * psb_pkg::BYTE_W,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] value,
  input  logic              unit_dw,
  input  logic [OFS_W-1:0]  base,
  input  logic [LANES-1:0]  mask,
  output logic [DATA_W-1:0] data
);
  localparam int HALF = LANES / 2;
  localparam int BW = psb_pkg::BYTE_W;

  function automatic logic [DATA_W-1:0] place_bytes(input logic [DATA_W-1:0] v,
                                                    input logic dw, input int b);
    logic [DATA_W-1:0] d;
    d = '0;
    for (int j = 0; j < LANES; j++) begin
      if (dw)
        d[BW*(LANES-1-j) +: BW] = v[BW*(LANES-1-j) +: BW];
      else if (j >= b && j < b + HALF)
        d[BW*(LANES-1-j) +: BW] = v[BW*(HALF-1-(j-b)) +: BW];
    end
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] expand(input logic [LANES-1:0] m);
    logic [DATA_W-1:0] e;
    for (int j = 0; j < LANES; j++) e[BW*(LANES-1-j) +: BW] = {BW{m[j]}};
    return e;
  endfunction

  logic [DATA_W-1:0] placed;

  always_comb begin
    placed = place_bytes(value, unit_dw, int'(base));
    data   = placed & expand(mask);
  end
endmodule

// File: rtl/psb_out_reg.sv
module psb_out_reg #(
  parameter int ADDR_W = 64,
  parameter int LANES  = 8,
  localparam int DATA_W = LANES * psb_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              take,
  input  logic [ADDR_W-1:0] n_addr,
  input  logic [DATA_W-1:0] n_data,
  input  logic [LANES-1:0]  n_be,
  input  logic              n_probe,
  input  logic              n_illegal,
  input  logic              n_wb_valid,
  input  logic [ADDR_W-1:0] n_wb_value,
  output logic              q_valid,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_data,
  output logic [LANES-1:0]  q_be,
  output logic              q_probe,
  output logic              q_illegal,
  output logic              q_wb_valid,
  output logic [ADDR_W-1:0] q_wb_value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid    <= 1'b0;
      q_addr     <= '0;
      q_data     <= '0;
      q_be       <= '0;
      q_probe    <= 1'b0;
      q_illegal  <= 1'b0;
      q_wb_valid <= 1'b0;
      q_wb_value <= '0;
    end else if (load) begin
      q_valid    <= 1'b1;
      q_addr     <= n_addr;
      q_data     <= n_data;
      q_be       <= n_be;
      q_probe    <= n_probe;
      q_illegal  <= n_illegal;
      q_wb_valid <= n_wb_valid;
      q_wb_value <= n_wb_value;
    end else if (take) begin
      q_valid    <= 1'b0;
      q_data     <= '0;
      q_be       <= '0;
      q_probe    <= 1'b0;
      q_illegal  <= 1'b0;
      q_wb_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/partial_store_steer.sv
module partial_store_steer #(
  parameter int ADDR_W = 64,
  parameter int LANES  = 8,
  localparam int DATA_W = LANES * psb_pkg::BYTE_W,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_value,
  input  logic              req_fill_end,
  input  logic              req_modify,
  input  logic              req_dword,
  input  logic              wide_en,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_be,
  output logic              wr_probe,
  output logic              wr_illegal,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_value
);
  localparam logic [OFS_W-1:0] HALF_BASE = OFS_W'(LANES / 2);

  // Named internal events, brought out for the checker
  logic                accept;
  logic                stall;
  logic                illegal;
  logic [OFS_W-1:0]    ofs;
  logic [OFS_W-1:0]    base;
  logic [LANES-1:0]    raw_mask;
  logic                zero_len;
  logic [LANES-1:0]    nxt_be;
  logic [DATA_W-1:0]   nxt_data;
  logic [ADDR_W-1:0]   nxt_addr;
  logic [ADDR_W-1:0]   nxt_wb;
  psb_pkg::fill_e      fill;

  assign req_ready = !wr_valid || wr_ready;
  assign accept    = req_valid && req_ready;
  assign stall     = wr_valid && !wr_ready;
  assign illegal   = req_dword && !wide_en;
  assign fill      = req_fill_end ? psb_pkg::FILL_END : psb_pkg::FILL_BEGIN;

  always_comb begin
    if (req_dword) begin
      ofs      = req_addr[OFS_W-1:0];
      base     = '0;
      nxt_addr = {req_addr[ADDR_W-1:OFS_W], OFS_W'(0)};
    end else begin
      ofs      = {1'b0, req_addr[OFS_W-2:0]};
      base     = req_addr[OFS_W-1] ? HALF_BASE : '0;
      nxt_addr = {req_addr[ADDR_W-1:OFS_W-1], (OFS_W-1)'(0)};
    end
    nxt_wb = {req_addr[ADDR_W-1:OFS_W], OFS_W'(0)};
    nxt_be = illegal ? '0 : raw_mask;
  end

  psb_mask_gen #(.LANES(LANES)) u_mask (
    .ofs      (ofs),
    .base     (base),
    .unit_dw  (req_dword),
    .fill     (fill),
    .mask     (raw_mask),
    .zero_len (zero_len)
  );

  psb_lane_align #(.LANES(LANES)) u_align (
    .value   (req_value),
    .unit_dw (req_dword),
    .base    (base),
    .mask    (nxt_be),
    .data    (nxt_data)
  );

  psb_out_reg #(.ADDR_W(ADDR_W), .LANES(LANES)) u_oreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .take       (wr_ready),
    .n_addr     (nxt_addr),
    .n_data     (nxt_data),
    .n_be       (nxt_be),
    .n_probe    (zero_len && !illegal),
    .n_illegal  (illegal),
    .n_wb_valid (req_modify && !illegal),
    .n_wb_value (nxt_wb),
    .q_valid    (wr_valid),
    .q_addr     (wr_addr),
    .q_data     (wr_data),
    .q_be       (wr_be),
    .q_probe    (wr_probe),
    .q_illegal  (wr_illegal),
    .q_wb_valid (wb_valid),
    .q_wb_value (wb_value)
  );
endmodule

// File: rtl/psb_steer_chk.sv
module psb_steer_chk #(
  parameter int ADDR_W = 64,
  parameter int LANES  = 8,
  localparam int DATA_W = LANES * 8,
  localparam int OFS_W  = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              stall,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [LANES-1:0]  wr_be,
  input logic              wr_probe,
  input logic              wr_illegal,
  input logic              wb_valid,
  input logic [ADDR_W-1:0] wb_value
);
  function automatic logic [DATA_W-1:0] lanes_of(input logic [LANES-1:0] m);
    logic [DATA_W-1:0] e;
    for (int j = 0; j < LANES; j++) e[8*(LANES-1-j) +: 8] = {8{m[j]}};
    return e;
  endfunction

  // R10
  idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> (wr_be == '0));

  // R10
  unmasked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((wr_data & ~lanes_of(wr_be)) == '0));

  // R9
  accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> wr_valid);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (wr_valid && $stable(wr_be) && $stable(wr_data) && $stable(wr_addr)
               && $stable(wr_probe) && $stable(wb_value)));

  // R7
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_illegal) |-> (wr_be == '0 && !wr_probe && !wb_valid));

  // R4
  probe_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_probe |-> (wr_valid && wr_be == '0));

  // R8
  wb_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wr_valid && wb_value[OFS_W-1:0] == '0));

  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[OFS_W-2:0] == '0));
endmodule

bind partial_store_steer psb_steer_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .stall      (stall),
  .wr_valid   (wr_valid),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .wr_be      (wr_be),
  .wr_probe   (wr_probe),
  .wr_illegal (wr_illegal),
  .wb_valid   (wb_valid),
  .wb_value   (wb_value)
);

// File: tb/partial_store_steer_bench.sv
module partial_store_steer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic [63:0] req_value = '0;
  logic        req_fill_end = 1'b0;
  logic        req_modify = 1'b0;
  logic        req_dword = 1'b0;
  logic        wide_en = 1'b0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [63:0] wr_addr;
  logic [63:0] wr_data;
  logic [7:0]  wr_be;
  logic        wr_probe;
  logic        wr_illegal;
  logic        wb_valid;
  logic [63:0] wb_value;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  partial_store_steer u_partial_store_steer (.*);

  typedef struct packed {
    logic [63:0] addr;
    logic        fend;
    logic        dw;
    logic        modify;
    logic        wide;
    logic [7:0]  be;
    logic [63:0] data;
    logic        probe;
    logic        ill;
  } vec_t;

  localparam logic [63:0] A  = 64'h0000_4000_0000_1A00;
  localparam logic [63:0] V1 = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] V2 = 64'hFEDC_BA98_7654_3210;
  localparam int NV = 14;

  localparam vec_t VECS [NV] = '{
    '{A+64'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 64'h0123456789ABCDEF, 1'b0, 1'b0}, // R2 k=0
    '{A+64'd3, 1'b0, 1'b1, 1'b1, 1'b1, 8'hF8, 64'h0000006789ABCDEF, 1'b0, 1'b0}, // R2 R6 k=3
    '{A+64'd7, 1'b0, 1'b1, 1'b0, 1'b1, 8'h80, 64'h00000000000000EF, 1'b0, 1'b0}, // R2 k=7
    '{A+64'd6, 1'b0, 1'b1, 1'b0, 1'b1, 8'hC0, 64'h000000000000CDEF, 1'b0, 1'b0}, // R2 k=6
    '{A+64'd5, 1'b1, 1'b1, 1'b1, 1'b1, 8'h1F, 64'h0123456789000000, 1'b0, 1'b0}, // R3 k=5
    '{A+64'd1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h01, 64'h0100000000000000, 1'b0, 1'b0}, // R3 k=1
    '{A+64'd7, 1'b1, 1'b1, 1'b0, 1'b1, 8'h7F, 64'h0123456789ABCD00, 1'b0, 1'b0}, // R3 k=7
    '{A+64'd0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 64'h0,                1'b1, 1'b0}, // R4 dword
    '{A+64'd5, 1'b0, 1'b0, 1'b1, 1'b1, 8'hE0, 64'h0000000000ABCDEF, 1'b0, 1'b0}, // R5 upper half
    '{A+64'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h03, 64'h89AB000000000000, 1'b0, 1'b0}, // R5 R7 word legal
    '{A+64'd3, 1'b1, 1'b0, 1'b0, 1'b1, 8'h07, 64'h89ABCD0000000000, 1'b0, 1'b0}, // R5 end k=3
    '{A+64'd4, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 64'h0,                1'b1, 1'b0}, // R4 word
    '{A+64'd6, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 64'h0,                1'b0, 1'b1}, // R7 illegal
    '{A+64'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0F, 64'h89ABCDEF00000000, 1'b0, 1'b0}  // R5 lower half
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] addr, input logic [63:0] val, input logic fend,
                       input logic dw, input logic modify, input logic wide);
    req_valid    = 1'b1;
    req_addr     = addr;
    req_value    = val;
    req_fill_end = fend;
    req_dword    = dw;
    req_modify   = modify;
    wide_en      = wide;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!wr_valid && wr_be == 8'h00 && !wr_probe && !wr_illegal && !wb_valid && req_ready,
        "R1 reset outputs", {wr_valid, wr_be, wr_probe, wr_illegal, wb_valid, req_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [63:0] exp_addr;
      logic        exp_wb;
      v = VECS[i];
      exp_addr = v.dw ? {v.addr[63:3], 3'b000} : {v.addr[63:2], 2'b00};
      exp_wb   = v.modify && !v.ill;
      wr_ready = 1'b1;
      drive(v.addr, V1, v.fend, v.dw, v.modify, v.wide);
      @(negedge clk);
      req_valid = 1'b0;
      chk(wr_valid, $sformatf("R9 vec%0d valid after accept", i), 64'(wr_valid), 64'd1);
      chk(wr_be == v.be, $sformatf("R2/R3/R5 R6 vec%0d byte enables", i), 64'(wr_be), 64'(v.be));
      chk(wr_data == v.data, $sformatf("R2/R3/R5 R10 vec%0d data", i), wr_data, v.data);
      chk(wr_addr == exp_addr, $sformatf("R2/R5 vec%0d address", i), wr_addr, exp_addr);
      chk(wr_probe == v.probe, $sformatf("R4 vec%0d probe", i), 64'(wr_probe), 64'(v.probe));
      chk(wr_illegal == v.ill, $sformatf("R7 vec%0d illegal", i), 64'(wr_illegal), 64'(v.ill));
      chk(wb_valid == exp_wb, $sformatf("R8 vec%0d wb valid", i), 64'(wb_valid), 64'(exp_wb));
      if (exp_wb)
        chk(wb_value == {v.addr[63:3], 3'b000}, $sformatf("R8 vec%0d wb value", i),
            wb_value, {v.addr[63:3], 3'b000});
      @(negedge clk);
      chk(!wr_valid && wr_be == 8'h00, $sformatf("R6 R10 vec%0d single transaction", i),
          {wr_valid, wr_be}, 64'h0);
    end

    // R9 backpressure: hold A while B waits
    wr_ready = 1'b0;
    drive(A + 64'd2, V2, 1'b0, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk(wr_valid && wr_be == 8'hFC && wr_data == 64'h0000BA9876543210, "R9 R2 first under stall",
        wr_data, 64'h0000BA9876543210);
    chk(!req_ready, "R9 ready low while stalled", 64'(req_ready), 64'd0);
    drive(A + 64'd4, V2, 1'b1, 1'b1, 1'b0, 1'b1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(wr_valid && wr_be == 8'hFC && wr_data == 64'h0000BA9876543210,
          "R9 held while stalled", {56'd0, wr_be}, 64'hFC);
    end
    wr_ready = 1'b1;
    #1;
    chk(req_ready, "R9 ready follows wr_ready", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(wr_valid && wr_be == 8'h0F && wr_data == 64'hFEDCBA9800000000, "R9 R3 queued request",
        wr_data, 64'hFEDCBA9800000000);
    @(negedge clk);
    chk(!wr_valid && wr_be == 8'h00 && req_ready, "R6 R10 drained", {wr_valid, wr_be}, 64'h0);

    // R1 reset while a transaction is pending
    wr_ready = 1'b0;
    drive(A + 64'd1, V2, 1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(!wr_valid && wr_be == 8'h00 && !wb_valid && req_ready, "R1 reset clears pending",
        {wr_valid, wr_be, wb_valid}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    wr_ready = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule